// File: doc/BRIEF.md
# Sliding-Window Register File

This block is the integer register file of a processor whose calling convention moves a window across a larger physical store. Instructions still see 32 registers of 32 bits. Register 0 is hard-wired to zero. Registers 1 to 7 are shared by every procedure. The other 24 registers are split into three groups of eight: outgoing (8..15), private (16..23) and incoming (24..31). The groups are located through a window pointer, so that a call moves the pointer forward by one window of 16 physical registers. After the move, the eight registers the caller wrote as outgoing arguments appear to the callee as its incoming registers. The private group of each procedure belongs to that procedure alone.

The physical store holds a ring of eight windows of 16 registers each, plus the seven shared registers. The block tracks how many windows are live. A call that would wrap onto a window still holding live state raises an overflow fault, and a return below the oldest live window raises an underflow fault. In both cases the pointer stays where it is, so that an external handler can spill or fill memory and retry. The block has two combinational read ports that forward a value being written in the same cycle, one write port, and a call input that also deposits a return address in outgoing register 7.

Top module: `wrf_top`

## Requirements
- R1: Reading address 0 on either port returns 0 in every cycle, and a write to address 0 has no effect.
- R2: Addresses 1 to 7 select the same seven storage words whatever the window pointer holds, so a value written in one window is read back unchanged in another.
- R3: After an accepted call, the callee reads the caller's address 8+k (k = 0..7) at its address 24+k.
- R4: Addresses 16 to 23 are private to a window: a fresh callee reads its own storage there, and after a return the caller reads back the values it left there.
- R5: An accepted return moves the pointer back by one window (7 wraps to 0 going forward, 0 to 7 going back), and the caller then reads the callee's addresses 24+k at its own addresses 8+k.
- R6: An accepted call writes `callLink` into the caller's address 15, which the callee reads at address 31.
- R7: Reset places the pointer at window 5 with one live window, and every accepted call adds one to the pointer modulo 8, so that the sequence 5,6,7,0,1,2,3 is reachable.
- R8: With 7 live windows, a call raises `ovfFault` in the same cycle. The pointer keeps its value and no return address is written.
- R9: With 1 live window, a return raises `unfFault` in the same cycle, and the pointer keeps its value.
- R10: A read of a nonzero address that the write port (or the return-address write of an accepted call) targets in the same cycle returns the value being written.
- R11: When call and return are requested together, the call alone is acted on and the return is ignored.
- R12: After reset every register reads 0, both fault outputs are low and `windowPtr` is 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rdAddrA | input | 5 | Architectural address, read port A |
| rdDataA | output | 32 | Read data A, combinational with forwarding |
| rdAddrB | input | 5 | Architectural address, read port B |
| rdDataB | output | 32 | Read data B, combinational with forwarding |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Architectural write address, decoded in the current window |
| wrData | input | 32 | Write data |
| callReq | input | 1 | Advance the window at the clock edge |
| retReq | input | 1 | Move the window back at the clock edge |
| callLink | input | 32 | Return address stored in outgoing register 7 by a call |
| windowPtr | output | 3 | Current window pointer |
| ovfFault | output | 1 | Call refused because no free window remains |
| unfFault | output | 1 | Return refused because no older window is live |

## Verification
The hardest state to reach is the wrap of the ring with the live chain at its limit. That state takes six accepted calls from the reset window, with the pointer passing from 7 to 0, and only then does a seventh call hit the overflow check. The bench gets there with a directed chain of calls. Each level first tags its private register 16 and then leaves a distinct return address. At the top it tries a refused call and confirms that outgoing register 15 was not touched. On the way down, six returns check every tag and link, and a final refused return checks the underflow.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  localparam int ARCH_REGS = 32;
  localparam int ADDR_W    = $clog2(ARCH_REGS);
  localparam int GROUP_SZ  = 8;
  localparam int WIN_REGS  = 2 * GROUP_SZ;
  localparam logic [ADDR_W-1:0] LINK_ADDR = ADDR_W'(15);

  typedef enum logic [1:0] {
    GRP_SHARED  = 2'd0,
    GRP_OUTGO   = 2'd1,
    GRP_PRIVATE = 2'd2,
    GRP_INCOME  = 2'd3
  } regGroup_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic userWrite;
    logic linkWrite;
  } winStrobe_t;

  function automatic regGroup_t groupOf(input logic [ADDR_W-1:0] a);
    return regGroup_t'(a[ADDR_W-1:ADDR_W-2]);
  endfunction

endpackage

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
  import wrf_pkg::*;
#(
  parameter int NWIN      = 8,
  parameter int START_WIN = 5,
  localparam int PTR_W    = $clog2(NWIN),
  localparam int DEPTH_W  = $clog2(NWIN + 1),
  localparam int MAX_LIVE = NWIN - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              callReq,
  input  logic              retReq,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output logic [PTR_W-1:0]  cwp,
  output winStrobe_t        strobe,
  output logic              ovfFault,
  output logic              unfFault
);

  logic [DEPTH_W-1:0] liveCnt;
  logic               callOk;
  logic               retSeen;
  logic               retOk;
  logic [PTR_W-1:0]   cwpInc;
  logic [PTR_W-1:0]   cwpDec;

  always_comb begin
    callOk   = callReq && (liveCnt < DEPTH_W'(MAX_LIVE));
    ovfFault = callReq && !callOk;
    retSeen  = retReq && !callReq;
    retOk    = retSeen && (liveCnt > DEPTH_W'(1));
    unfFault = retSeen && !retOk;
    cwpInc   = (cwp == PTR_W'(NWIN - 1)) ? '0 : cwp + PTR_W'(1);
    cwpDec   = (cwp == '0) ? PTR_W'(NWIN - 1) : cwp - PTR_W'(1);
    strobe.userWrite = wrEn && (wrAddr != '0);
    strobe.linkWrite = callOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cwp     <= PTR_W'(START_WIN);
      liveCnt <= DEPTH_W'(1);
    end else if (callOk) begin
      cwp     <= cwpInc;
      liveCnt <= liveCnt + DEPTH_W'(1);
    end else if (retOk) begin
      cwp     <= cwpDec;
      liveCnt <= liveCnt - DEPTH_W'(1);
    end
  end

endmodule

// File: rtl/wrf_data.sv
module wrf_data
  import wrf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NWIN    = 8,
  parameter int NPORTS  = 2,
  localparam int PTR_W  = $clog2(NWIN),
  localparam int RING   = NWIN * WIN_REGS,
  localparam int RING_W = $clog2(RING),
  localparam int NSHARE = GROUP_SZ
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [PTR_W-1:0]               cwp,
  input  winStrobe_t                     strobe,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [DATA_W-1:0]              callLink,
  input  logic [NPORTS-1:0][ADDR_W-1:0]  rdAddr,
  output logic [NPORTS-1:0][DATA_W-1:0]  rdData
);

  logic [DATA_W-1:0] shareReg [NSHARE];
  logic [DATA_W-1:0] ringReg  [RING];

  // windowed address -> ring slot: ins at base, privates at +8, outs at +16
  function automatic logic [RING_W-1:0] ringSlot(input logic [ADDR_W-1:0] a,
                                                 input logic [PTR_W-1:0]  w);
    int s;
    int off;
    case (groupOf(a))
      GRP_INCOME:  off = 0;
      GRP_PRIVATE: off = GROUP_SZ;
      default:     off = WIN_REGS;
    endcase
    s = int'(w) * WIN_REGS + off + int'(a[2:0]);
    if (s >= RING) s = s - RING;
    return RING_W'(s);
  endfunction

  logic              wrShared;
  logic              wrRing;
  logic [RING_W-1:0] wrSlot;
  logic [RING_W-1:0] linkSlot;

  always_comb begin
    wrShared = strobe.userWrite && (groupOf(wrAddr) == GRP_SHARED);
    wrRing   = strobe.userWrite && (groupOf(wrAddr) != GRP_SHARED);
    wrSlot   = ringSlot(wrAddr, cwp);
    linkSlot = ringSlot(LINK_ADDR, cwp);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NSHARE; i++) shareReg[i] <= '0;
      for (int i = 0; i < RING; i++)   ringReg[i]  <= '0;
    end else begin
      if (wrShared) shareReg[wrAddr[2:0]] <= wrData;
      if (wrRing)   ringReg[wrSlot]       <= wrData;
      if (strobe.linkWrite) ringReg[linkSlot] <= callLink;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_read
    logic [RING_W-1:0] rdSlot;
    always_comb begin
      rdSlot = ringSlot(rdAddr[p], cwp);
      if (rdAddr[p] == '0) begin
        rdData[p] = '0;
      end else if (groupOf(rdAddr[p]) == GRP_SHARED) begin
        if (wrShared && (wrAddr == rdAddr[p])) rdData[p] = wrData;
        else                                   rdData[p] = shareReg[rdAddr[p][2:0]];
      end else begin
        if (strobe.linkWrite && (linkSlot == rdSlot)) rdData[p] = callLink;
        else if (wrRing && (wrSlot == rdSlot))        rdData[p] = wrData;
        else                                          rdData[p] = ringReg[rdSlot];
      end
    end
  end

endmodule

// File: rtl/wrf_top.sv
module wrf_top
  import wrf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NWIN      = 8,
  parameter int START_WIN = 5,
  localparam int PTR_W    = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [4:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [4:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              callReq,
  input  logic              retReq,
  input  logic [DATA_W-1:0] callLink,
  output logic [PTR_W-1:0]  windowPtr,
  output logic              ovfFault,
  output logic              unfFault
);

  winStrobe_t                    strobe;
  logic [1:0][ADDR_W-1:0]        rdAddr;
  logic [1:0][DATA_W-1:0]        rdData;

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  wrf_ctrl #(.NWIN(NWIN), .START_WIN(START_WIN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .callReq  (callReq),
    .retReq   (retReq),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .cwp      (windowPtr),
    .strobe   (strobe),
    .ovfFault (ovfFault),
    .unfFault (unfFault)
  );

  wrf_data #(.DATA_W(DATA_W), .NWIN(NWIN), .NPORTS(2)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .cwp      (windowPtr),
    .strobe   (strobe),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .callLink (callLink),
    .rdAddr   (rdAddr),
    .rdData   (rdData)
  );

endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
  parameter int DATA_W = 32,
  parameter int NWIN   = 8,
  localparam int PTR_W = $clog2(NWIN)
) (
  input logic              clk,
  input logic              rstN,
  input logic [4:0]        rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [4:0]        rdAddrB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [4:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              callReq,
  input logic              retReq,
  input logic [PTR_W-1:0]  windowPtr,
  input logic              ovfFault,
  input logic              unfFault
);

  p_zero_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == '0) |-> (rdDataA == '0) && ((rdAddrB != '0) || (rdDataB == '0)));

  p_call_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (callReq && !ovfFault) |=>
      (windowPtr == (($past(windowPtr) == PTR_W'(NWIN - 1)) ? '0 : $past(windowPtr) + PTR_W'(1))));

  p_ret_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !callReq && !unfFault) |=>
      (windowPtr == (($past(windowPtr) == '0) ? PTR_W'(NWIN - 1) : $past(windowPtr) - PTR_W'(1))));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovfFault |=> $stable(windowPtr));

  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    unfFault |=> $stable(windowPtr));

  p_call_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (callReq && retReq) |-> !unfFault);

  p_fault_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovfFault |-> callReq && !unfFault);

  p_forward_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !callReq && (wrAddr != '0) && (wrAddr == rdAddrA)) |-> (rdDataA == wrData));

endmodule

bind wrf_top wrf_checker #(.DATA_W(DATA_W), .NWIN(NWIN)) u_wrf_checker (
  .clk       (clk),
  .rstN      (rstN),
  .rdAddrA   (rdAddrA),
  .rdDataA   (rdDataA),
  .rdAddrB   (rdAddrB),
  .rdDataB   (rdDataB),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .callReq   (callReq),
  .retReq    (retReq),
  .windowPtr (windowPtr),
  .ovfFault  (ovfFault),
  .unfFault  (unfFault)
);

// File: tb/test_wrf_top.sv
module test_wrf_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  rdAddrA, rdAddrB, wrAddr;
  logic [31:0] rdDataA, rdDataB, wrData, callLink;
  logic        wrEn, callReq, retReq;
  logic [2:0]  windowPtr;
  logic        ovfFault, unfFault;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wrf_top i_wrf_top (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .callReq(callReq), .retReq(retReq), .callLink(callLink),
    .windowPtr(windowPtr), .ovfFault(ovfFault), .unfFault(unfFault)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        cl;
    logic        rt;
    logic [31:0] lk;
    logic [4:0]  ra;
    logic [31:0] ea;
    logic [4:0]  rb;
    logic [31:0] eb;
    logic [2:0]  ep;
    logic        eo;
    logic        eu;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{"R1 ", 1'b1, 5'd0,  32'hDEAD, 1'b0, 1'b0, 32'h0,   5'd0,  32'h0,    5'd0,  32'h0,    3'd5, 1'b0, 1'b0},
    '{"R12", 1'b0, 5'd0,  32'h0,    1'b0, 1'b0, 32'h0,   5'd0,  32'h0,    5'd3,  32'h0,    3'd5, 1'b0, 1'b0},
    '{"R10", 1'b1, 5'd3,  32'h33,   1'b0, 1'b0, 32'h0,   5'd3,  32'h33,   5'd3,  32'h33,   3'd5, 1'b0, 1'b0},
    '{"R10", 1'b1, 5'd8,  32'h88,   1'b0, 1'b0, 32'h0,   5'd3,  32'h33,   5'd8,  32'h88,   3'd5, 1'b0, 1'b0},
    '{"R10", 1'b1, 5'd16, 32'h1616, 1'b0, 1'b0, 32'h0,   5'd8,  32'h88,   5'd16, 32'h1616, 3'd5, 1'b0, 1'b0},
    '{"R6 ", 1'b1, 5'd9,  32'h99,   1'b1, 1'b0, 32'h400, 5'd15, 32'h400,  5'd9,  32'h99,   3'd5, 1'b0, 1'b0},
    '{"R3 ", 1'b0, 5'd0,  32'h0,    1'b0, 1'b0, 32'h0,   5'd24, 32'h88,   5'd31, 32'h400,  3'd6, 1'b0, 1'b0},
    '{"R2 ", 1'b0, 5'd0,  32'h0,    1'b0, 1'b0, 32'h0,   5'd25, 32'h99,   5'd3,  32'h33,   3'd6, 1'b0, 1'b0},
    '{"R4 ", 1'b1, 5'd16, 32'hAAAA, 1'b0, 1'b0, 32'h0,   5'd17, 32'h0,    5'd16, 32'hAAAA, 3'd6, 1'b0, 1'b0},
    '{"R5 ", 1'b1, 5'd3,  32'h77,   1'b0, 1'b1, 32'h0,   5'd16, 32'hAAAA, 5'd26, 32'h0,    3'd6, 1'b0, 1'b0},
    '{"R4 ", 1'b0, 5'd0,  32'h0,    1'b0, 1'b0, 32'h0,   5'd3,  32'h77,   5'd16, 32'h1616, 3'd5, 1'b0, 1'b0},
    '{"R5 ", 1'b0, 5'd0,  32'h0,    1'b0, 1'b0, 32'h0,   5'd8,  32'h88,   5'd15, 32'h400,  3'd5, 1'b0, 1'b0},
    '{"R9 ", 1'b0, 5'd0,  32'h0,    1'b0, 1'b1, 32'h0,   5'd9,  32'h99,   5'd0,  32'h0,    3'd5, 1'b0, 1'b1},
    '{"R11", 1'b0, 5'd0,  32'h0,    1'b1, 1'b1, 32'h500, 5'd15, 32'h500,  5'd0,  32'h0,    3'd5, 1'b0, 1'b0},
    '{"R11", 1'b0, 5'd0,  32'h0,    1'b0, 1'b0, 32'h0,   5'd31, 32'h500,  5'd24, 32'h88,   3'd6, 1'b0, 1'b0},
    '{"R5 ", 1'b0, 5'd0,  32'h0,    1'b0, 1'b1, 32'h0,   5'd0,  32'h0,    5'd31, 32'h500,  3'd6, 1'b0, 1'b0},
    '{"R5 ", 1'b0, 5'd0,  32'h0,    1'b0, 1'b0, 32'h0,   5'd15, 32'h500,  5'd9,  32'h99,   3'd5, 1'b0, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one cycle of inputs after a falling edge; outputs then reflect pre-edge state
  task automatic drive(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                       input logic cl, input logic rt, input logic [31:0] lk,
                       input logic [4:0] ra, input logic [4:0] rb);
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrData = wd;
    callReq = cl; retReq = rt; callLink = lk;
    rdAddrA = ra; rdAddrB = rb;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rstN = 1'b0;
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
    callReq = 1'b0; retReq = 1'b0; callLink = '0;
    rdAddrA = '0; rdAddrB = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R12: reset state
    drive(1'b0, 5'd0, '0, 1'b0, 1'b0, '0, 5'd5, 5'd20);
    check("R12", "ptr", 32'(windowPtr), 32'd5);
    check("R12", "global", rdDataA, 32'h0);
    check("R12", "private", rdDataB, 32'h0);
    check("R12", "faults", {30'b0, ovfFault, unfFault}, 32'h0);

    // table of stimulus and expected values
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].we, VECS[i].wa, VECS[i].wd, VECS[i].cl, VECS[i].rt,
            VECS[i].lk, VECS[i].ra, VECS[i].rb);
      check(string'(VECS[i].tag), "readA", rdDataA, VECS[i].ea);
      check(string'(VECS[i].tag), "readB", rdDataB, VECS[i].eb);
      check(string'(VECS[i].tag), "ptr", 32'(windowPtr), 32'(VECS[i].ep));
      check(string'(VECS[i].tag), "ovf", 32'(ovfFault), 32'(VECS[i].eo));
      check(string'(VECS[i].tag), "unf", 32'(unfFault), 32'(VECS[i].eu));
    end

    // R7 / R4: chain of calls through the wrap point, tagging each private reg
    for (int k = 0; k < 6; k++) begin
      drive(1'b1, 5'd16, 32'h1000 + k, 1'b0, 1'b0, '0, 5'd16, 5'd0);
      check("R7", "ptr", 32'(windowPtr), 32'((5 + k) % 8));
      check("R10", "private fwd", rdDataA, 32'h1000 + k);
      drive(1'b0, 5'd0, '0, 1'b1, 1'b0, 32'h2000 + k, 5'd15, 5'd0);
      check("R6", "link fwd", rdDataA, 32'h2000 + k);
      check("R8", "no ovf", 32'(ovfFault), 32'd0);
    end
    drive(1'b1, 5'd16, 32'h1006, 1'b0, 1'b0, '0, 5'd15, 5'd0);
    check("R7", "ptr after wrap", 32'(windowPtr), 32'd3);

    // R8: refused call at the limit
    drive(1'b0, 5'd0, '0, 1'b1, 1'b0, 32'hBAD, 5'd15, 5'd0);
    check("R8", "ovf", 32'(ovfFault), 32'd1);
    check("R8", "no link fwd", rdDataA, 32'h0);
    drive(1'b0, 5'd0, '0, 1'b0, 1'b0, '0, 5'd15, 5'd0);
    check("R8", "ptr held", 32'(windowPtr), 32'd3);
    check("R8", "link not written", rdDataA, 32'h0);
    check("R8", "ovf clear", 32'(ovfFault), 32'd0);

    // R4 / R5: unwind, checking private tags and links
    for (int k = 6; k >= 1; k--) begin
      drive(1'b0, 5'd0, '0, 1'b0, 1'b1, '0, 5'd16, 5'd31);
      check("R4", "private tag", rdDataA, 32'h1000 + k);
      check("R6", "incoming link", rdDataB, 32'h2000 + k - 1);
      check("R5", "ptr", 32'(windowPtr), 32'((5 + k) % 8));
      check("R9", "no unf", 32'(unfFault), 32'd0);
    end
    drive(1'b0, 5'd0, '0, 1'b0, 1'b0, '0, 5'd16, 5'd15);
    check("R4", "base private", rdDataA, 32'h1000);
    check("R5", "base outgoing link", rdDataB, 32'h2000);
    check("R5", "ptr base", 32'(windowPtr), 32'd5);

    // R9: refused return
    drive(1'b0, 5'd0, '0, 1'b0, 1'b1, '0, 5'd0, 5'd0);
    check("R9", "unf", 32'(unfFault), 32'd1);
    drive(1'b0, 5'd0, '0, 1'b0, 1'b0, '0, 5'd16, 5'd0);
    check("R9", "ptr held", 32'(windowPtr), 32'd5);
    check("R9", "private kept", rdDataA, 32'h1000);

    // R12: second reset clears storage
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    drive(1'b0, 5'd0, '0, 1'b0, 1'b0, '0, 5'd3, 5'd16);
    check("R12", "ptr", 32'(windowPtr), 32'd5);
    check("R12", "global cleared", rdDataA, 32'h0);
    check("R12", "private cleared", rdDataB, 32'h0);

    @(negedge clk);
    finish_run();
  end

endmodule